// File: doc/BRIEF.md
# Block-Mode Peripheral DMA Channel

This block is one DMA channel that copies a run of 32-bit words between system memory and a single peripheral data port. Software loads three registers through a simple write port: a start address, a block-shape word and a control word. The block-shape word holds two 16-bit fields. The upper field is the number of blocks and the lower field is the number of words per block. The channel moves the product of the two. Writing the control word with bit 24 set starts the channel. Only two exact control values are accepted as transfers. Any other value with bit 24 set ends the run at once, with no traffic.

The memory side is a word-addressed request port with a ready handshake. The peripheral side is a push port for memory-to-peripheral runs and a pop port for peripheral-to-memory runs. Either side can stall the engine. Each word is first read into a holding register and then written out, so only one side is active at any time.

When the run ends, the channel does three things. It writes back the final address when words were moved. It clears bit 24 of the control register. It pulses its interrupt for one cycle.

The state machine has seven states, listed here with their transitions:
- IDLE: goes to CHECK on a control write that has bit 24 set.
- CHECK: goes to DONE when the code is unknown, the address is out of range or the count is zero. Otherwise it goes to MEM_RD for memory-to-peripheral runs and to POP for peripheral-to-memory runs.
- MEM_RD: goes to PUSH when memory accepts the read.
- PUSH: goes back to MEM_RD, or to DONE on the last word, when the peripheral accepts the word.
- POP: goes to MEM_WR when the peripheral offers a word.
- MEM_WR: goes back to POP, or to DONE on the last word, when memory accepts the write.
- DONE: always goes to IDLE.

Top module: `blk_dma_chan`

## Requirements
- R1: The number of words moved equals reg bits [31:16] times bits [15:0] of the block-shape register. The register select codes are: 0 for address, 1 for block-shape, 2 for control. Select code 3 is ignored.
- R2: Control value 0x01000201 reads memory words in ascending word-address order and pushes each one, in that order, to the peripheral.
- R3: Control value 0x01000200 pops peripheral words and writes them in ascending word-address order. No word beyond the last one is touched.
- R4: When a started run ends, bit 24 of the control register reads 0 and the interrupt pulses high for exactly one cycle. While the interrupt is high, bit 24 is already clear.
- R5: After a run that moved words, the address register holds the start address plus 4 times the word count.
- R6: A control write with bit 24 set and any other value causes no memory or peripheral traffic. The stored value keeps its other bits, bit 24 is cleared, the interrupt pulses, and the address is unchanged. A control write with bit 24 clear only stores the value and starts nothing.
- R7: A start address at or above MEM_BYTES skips the run. There is no traffic, the address is unchanged, bit 24 is cleared and the interrupt pulses.
- R8: A word count of zero finishes with the interrupt and no memory or peripheral access.
- R9: Address bits [1:0] do not affect the memory word address, which is the address bits from bit 2 upward. Those low bits are kept in the final address.
- R10: A memory request or a push stays asserted, with its address and data held, until ready is seen. No word is lost or repeated under stalls.
- R11: Register writes made while bit 24 is set are ignored.
- R12: After reset, the address and control registers read 0, the interrupt is low and no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 block-shape, 2 control |
| reg_wdata | input | 32 | Register write data |
| addr_o | output | 32 | Address register contents |
| ctl_o | output | 32 | Control register contents; bit 24 means busy |
| irq | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | WAW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the request |
| push_valid | output | 1 | Word offered to the peripheral |
| push_data | output | 32 | Word to the peripheral |
| push_ready | input | 1 | Peripheral takes the word |
| pop_valid | input | 1 | Peripheral offers a word |
| pop_data | input | 32 | Word from the peripheral |
| pop_ready | output | 1 | Channel takes the word |

## Verification
The bench sweeps both directions over every pair of block and word counts from 0 to 3. The memory and peripheral ready signals are driven by a pseudo-random pattern, so stalls land on every state.

Several kinds of faulty design would show up here:
- A design that adds the two fields instead of multiplying them moves the wrong number of words.
- A design that repeats or drops a word under a stall corrupts the pushed stream or the memory image.
- A design that lets the low address bits into the word address, or masks them out of the final address, produces a wrong address value.

Three abort paths are run separately: unknown control codes, an out-of-range address and a zero count. Each must give exactly one interrupt and no traffic. A design that starts an abort run, or leaves bit 24 set, shows up there. Writes made during a long stalled run check that a busy channel cannot be redirected.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;

    localparam logic [31:0] CTL_MEM2PER = 32'h0100_0201;
    localparam logic [31:0] CTL_PER2MEM = 32'h0100_0200;
    localparam int          START_BIT   = 24;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_MEM_RD,
        S_PUSH,
        S_POP,
        S_MEM_WR,
        S_DONE
    } dma_state_t;

    typedef enum logic [1:0] {
        REG_ADDR = 2'd0,
        REG_BLK  = 2'd1,
        REG_CTL  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_t;

    typedef enum logic {
        DIR_TO_PER   = 1'b0,
        DIR_FROM_PER = 1'b1
    } dma_dir_t;

endpackage

// File: rtl/blk_dma_decode.sv
module blk_dma_decode
    import blk_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] ctl,
    output logic          known,
    output dma_dir_t      dir
);

    always_comb begin
        known = 1'b0;
        dir   = DIR_TO_PER;
        if (ctl == DW'(CTL_MEM2PER)) begin
            known = 1'b1;
            dir   = DIR_TO_PER;
        end else if (ctl == DW'(CTL_PER2MEM)) begin
            known = 1'b1;
            dir   = DIR_FROM_PER;
        end
    end

endmodule

// File: rtl/blk_dma_count.sv
module blk_dma_count #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2*FW-1:0] shape,
    input  logic          load,
    input  logic          step,
    output logic          zero,
    output logic          last
);

    localparam int CW = 2 * FW;

    logic [CW-1:0] total;
    logic [CW-1:0] remain_q;

    assign total = CW'(shape[CW-1:FW]) * CW'(shape[FW-1:0]);
    assign zero  = (total == '0);
    assign last  = (remain_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= total;
        end else if (step) begin
            remain_q <= remain_q - CW'(1);
        end
    end

endmodule

// File: rtl/blk_dma_ptr.sv
module blk_dma_ptr #(
    parameter int AW  = 32,
    parameter int WAW = 19
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  start,
    input  logic           load,
    input  logic           step,
    output logic [AW-1:0]  ptr,
    output logic [WAW-1:0] word_addr
);

    localparam logic [AW-1:0] BYTE_STEP = AW'(4);

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= start;
        end else if (step) begin
            ptr_q <= ptr_q + BYTE_STEP;
        end
    end

    assign ptr       = ptr_q;
    assign word_addr = ptr_q[WAW+1:2];

endmodule

// File: rtl/blk_dma_chan.sv
module blk_dma_chan
    import blk_dma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int FW        = 16,
    parameter int MEM_BYTES = 32'h0020_0000,
    localparam int WAW      = $clog2(MEM_BYTES) - 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [1:0]     reg_sel,
    input  logic [31:0]    reg_wdata,
    output logic [AW-1:0]  addr_o,
    output logic [31:0]    ctl_o,
    output logic           irq,
    output logic           mem_req,
    output logic           mem_we,
    output logic [WAW-1:0] mem_addr,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ready,
    output logic           push_valid,
    output logic [31:0]    push_data,
    input  logic           push_ready,
    input  logic           pop_valid,
    input  logic [31:0]    pop_data,
    output logic           pop_ready
);

    localparam logic [AW-1:0] MEM_LIMIT = AW'(MEM_BYTES);

    dma_state_t     state_q, state_d;
    logic [AW-1:0]  addr_q;
    logic [2*FW-1:0] shape_q;
    logic [31:0]    ctl_q;
    logic [31:0]    hold_q;
    logic           upd_q;
    logic           irq_q;

    logic           code_known;
    dma_dir_t       code_dir;
    logic           cnt_zero;
    logic           cnt_last;
    logic [AW-1:0]  ptr;
    logic [WAW-1:0] word_addr;

    logic           start_wr;
    logic           addr_ok;
    logic           go_xfer;
    logic           step;
    logic           load;

    blk_dma_decode #(.DW(32)) u_decode (
        .ctl   (ctl_q),
        .known (code_known),
        .dir   (code_dir)
    );

    blk_dma_count #(.FW(FW)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .shape (shape_q),
        .load  (load),
        .step  (step),
        .zero  (cnt_zero),
        .last  (cnt_last)
    );

    blk_dma_ptr #(.AW(AW), .WAW(WAW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (addr_q),
        .load      (load),
        .step      (step),
        .ptr       (ptr),
        .word_addr (word_addr)
    );

    assign start_wr = (state_q == S_IDLE) && reg_we &&
                      (reg_sel == REG_CTL) && reg_wdata[START_BIT];
    assign addr_ok  = (addr_q < MEM_LIMIT);
    assign go_xfer  = code_known && addr_ok && !cnt_zero;
    assign load     = (state_q == S_CHECK);
    assign step     = ((state_q == S_PUSH) && push_ready) ||
                      ((state_q == S_MEM_WR) && mem_ready);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_wr) state_d = S_CHECK;
            S_CHECK: begin
                if (!go_xfer)                 state_d = S_DONE;
                else if (code_dir == DIR_TO_PER) state_d = S_MEM_RD;
                else                          state_d = S_POP;
            end
            S_MEM_RD: if (mem_ready) state_d = S_PUSH;
            S_PUSH:   if (push_ready) state_d = cnt_last ? S_DONE : S_MEM_RD;
            S_POP:    if (pop_valid) state_d = S_MEM_WR;
            S_MEM_WR: if (mem_ready) state_d = cnt_last ? S_DONE : S_POP;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        push_valid = 1'b0;
        pop_ready  = 1'b0;
        unique case (state_q)
            S_MEM_RD: mem_req = 1'b1;
            S_MEM_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_PUSH:   push_valid = 1'b1;
            S_POP:    pop_ready  = 1'b1;
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    assign mem_addr  = word_addr;
    assign mem_wdata = hold_q;
    assign push_data = hold_q;

    // registers and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            shape_q <= '0;
            ctl_q   <= '0;
            hold_q  <= '0;
            upd_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= (state_q == S_DONE);
            if ((state_q == S_IDLE) && reg_we) begin
                unique case (reg_sel)
                    REG_ADDR: addr_q  <= AW'(reg_wdata);
                    REG_BLK:  shape_q <= (2*FW)'(reg_wdata);
                    REG_CTL:  ctl_q   <= reg_wdata;
                    default:  ctl_q   <= ctl_q;
                endcase
            end
            if (state_q == S_CHECK) begin
                upd_q <= go_xfer;
            end
            if ((state_q == S_MEM_RD) && mem_ready) begin
                hold_q <= mem_rdata;
            end
            if ((state_q == S_POP) && pop_valid) begin
                hold_q <= pop_data;
            end
            if (state_q == S_DONE) begin
                ctl_q[START_BIT] <= 1'b0;
                if (upd_q) begin
                    addr_q <= ptr;
                end
            end
        end
    end

    assign addr_o = addr_q;
    assign ctl_o  = ctl_q;
    assign irq    = irq_q;

endmodule

// File: rtl/blk_dma_chan_chk.sv
module blk_dma_chan_chk #(
    parameter int AW  = 32,
    parameter int WAW = 19
) (
    input logic           clk,
    input logic           rst_n,
    input logic           irq,
    input logic [AW-1:0]  addr_o,
    input logic [31:0]    ctl_o,
    input logic           mem_req,
    input logic           mem_we,
    input logic [WAW-1:0] mem_addr,
    input logic           mem_ready,
    input logic           push_valid,
    input logic [31:0]    push_data,
    input logic           push_ready,
    input logic           pop_ready
);

    assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !ctl_o[24]);

    assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_push_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));

    assert_no_traffic_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_o[24] |-> (!mem_req && !push_valid && !pop_ready));

    assert_addr_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[24] && $past(ctl_o[24])) |-> $stable(addr_o));

    assert_one_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_valid && pop_ready));

endmodule

bind blk_dma_chan blk_dma_chan_chk #(.AW(AW), .WAW(WAW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .addr_o     (addr_o),
    .ctl_o      (ctl_o),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ready  (mem_ready),
    .push_valid (push_valid),
    .push_data  (push_data),
    .push_ready (push_ready),
    .pop_ready  (pop_ready)
);

// File: tb/blk_dma_chan_tb.sv
`timescale 1ns/1ps
module blk_dma_chan_tb;

    localparam int WAW = 19;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [1:0]     reg_sel = 2'd0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    addr_o;
    logic [31:0]    ctl_o;
    logic           irq;
    logic           mem_req;
    logic           mem_we;
    logic [WAW-1:0] mem_addr;
    logic [31:0]    mem_wdata;
    logic [31:0]    mem_rdata;
    logic           mem_ready = 1'b0;
    logic           push_valid;
    logic [31:0]    push_data;
    logic           push_ready = 1'b0;
    logic           pop_valid = 1'b0;
    logic [31:0]    pop_data;
    logic           pop_ready;

    int total = 0;
    int bad = 0;
    logic [31:0] mem [0:255];
    logic [31:0] pbuf [0:255];
    int macc = 0;
    int pcnt = 0;
    int popcnt = 0;
    logic [7:0] lfsr = 8'h01;

    always #2 clk = ~clk;

    blk_dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .addr_o(addr_o), .ctl_o(ctl_o), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
        .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    assign pop_data  = 32'hA000_0000 + popcnt;

    // memory and peripheral models
    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            macc <= macc + 1;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        end
        if (push_valid && push_ready) begin
            pbuf[pcnt[7:0]] <= push_data;
            pcnt <= pcnt + 1;
        end
        if (pop_valid && pop_ready) popcnt <= popcnt + 1;
    end

    // stall pattern
    always @(negedge clk) begin
        lfsr <= lfsr[0] ? ((lfsr >> 1) ^ 8'hB8) : (lfsr >> 1);
        mem_ready  <= lfsr[0] | lfsr[3];
        pop_valid  <= lfsr[1] | lfsr[5];
        push_ready <= lfsr[2] | lfsr[6];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clear_models();
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 32'h5EED_0000 + i;
        macc = 0; pcnt = 0; popcnt = 0;
    endtask

    task automatic wait_done(output int pulses);
        int t = 0;
        int after = 0;
        pulses = 0;
        while (t < 3000 && after < 8) begin
            @(negedge clk);
            t++;
            if (irq) pulses++;
            if (pulses > 0) after++;
        end
    endtask

    task automatic run_xfer(input bit to_mem, input logic [31:0] start,
                            input int nb, input int nw);
        int n;
        int pulses;
        int sw;
        int errs;
        logic [31:0] code;
        n = nb * nw;
        sw = int'(start[9:2]);
        code = to_mem ? 32'h0100_0200 : 32'h0100_0201;
        clear_models();
        write_reg(2'd0, start);
        write_reg(2'd1, {16'(nb), 16'(nw)});
        write_reg(2'd2, code);
        wait_done(pulses);
        chk(pulses == 1, "R4 irq pulses", pulses, 1);
        chk(ctl_o == (code & ~32'h0100_0000), "R4 ctl after", ctl_o, code & ~32'h0100_0000);
        chk(addr_o == start + 32'(4 * n), "R5 R9 final addr", addr_o, start + 32'(4 * n));
        chk(macc == n, "R1 R8 memory accesses", macc, n);
        errs = 0;
        if (!to_mem) begin
            chk(pcnt == n, "R1 R2 push count", pcnt, n);
            for (int i = 0; i < n; i++)
                if (pbuf[i] !== 32'h5EED_0000 + sw + i) errs++;
            chk(errs == 0, "R2 R9 R10 pushed data", errs, 0);
        end else begin
            chk(popcnt == n, "R1 R3 pop count", popcnt, n);
            for (int i = 0; i < n; i++)
                if (mem[sw + i] !== 32'hA000_0000 + i) errs++;
            chk(errs == 0, "R3 R9 R10 written data", errs, 0);
            chk(mem[sw + n] == 32'h5EED_0000 + sw + n, "R3 no overrun",
                mem[sw + n], 32'h5EED_0000 + sw + n);
        end
    endtask

    task automatic run_abort(input logic [31:0] start, input logic [31:0] code, input string req);
        int pulses;
        clear_models();
        write_reg(2'd0, start);
        write_reg(2'd1, {16'd2, 16'd3});
        write_reg(2'd2, code);
        wait_done(pulses);
        chk(pulses == 1, {req, " irq"}, pulses, 1);
        chk(macc == 0 && pcnt == 0 && popcnt == 0, {req, " no traffic"}, macc + pcnt + popcnt, 0);
        chk(addr_o == start, {req, " addr kept"}, addr_o, start);
        chk(ctl_o == (code & ~32'h0100_0000), {req, " ctl"}, ctl_o, code & ~32'h0100_0000);
    endtask

    initial begin
        #600000;
        bad++; total++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int pulses;
        for (int i = 0; i < 256; i++) begin mem[i] = '0; pbuf[i] = '0; end
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(addr_o == 0, "R12 addr", addr_o, 0);
        chk(ctl_o == 0, "R12 ctl", ctl_o, 0);
        chk(irq == 0 && mem_req == 0 && push_valid == 0 && pop_ready == 0, "R12 quiet",
            {irq, mem_req, push_valid, pop_ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R5 R8 R9 sweep
        for (int d = 0; d < 2; d++)
            for (int nb = 0; nb < 4; nb++)
                for (int nw = 0; nw < 4; nw++)
                    run_xfer(d[0], 32'h40 + 32'((nb * 4 + nw) * 4) + 32'(nb % 4), nb, nw);

        // R6 unknown codes
        run_abort(32'h100, 32'h0100_0202, "R6 code 202");
        run_abort(32'h104, 32'h0100_0401, "R6 code 401");
        run_abort(32'h108, 32'h1100_0201, "R6 extra bit");
        // R7 out of range address
        run_abort(32'h0030_0000, 32'h0100_0201, "R7 bad addr");
        run_abort(32'h0020_0000, 32'h0100_0200, "R7 limit addr");

        // R6 write without start bit
        clear_models();
        write_reg(2'd0, 32'h80);
        write_reg(2'd1, {16'd1, 16'd2});
        write_reg(2'd2, 32'h0000_0201);
        pulses = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (irq) pulses++; end
        chk(pulses == 0, "R6 no start irq", pulses, 0);
        chk(macc == 0 && pcnt == 0, "R6 no start traffic", macc + pcnt, 0);
        chk(ctl_o == 32'h0000_0201, "R6 stored ctl", ctl_o, 32'h0000_0201);

        // R1 select code 3 ignored
        write_reg(2'd3, 32'h0100_0201);
        chk(ctl_o == 32'h0000_0201 && addr_o == 32'h80, "R1 sel3 ignored", ctl_o, 32'h0000_0201);

        // R11 writes while busy ignored
        clear_models();
        write_reg(2'd0, 32'h200);
        write_reg(2'd1, {16'd3, 16'd3});
        write_reg(2'd2, 32'h0100_0200);
        write_reg(2'd0, 32'h999);
        write_reg(2'd1, {16'd1, 16'd1});
        write_reg(2'd2, 32'h0000_0000);
        wait_done(pulses);
        chk(pulses == 1, "R11 irq", pulses, 1);
        chk(popcnt == 9, "R11 count kept", popcnt, 9);
        chk(addr_o == 32'h224, "R11 addr kept", addr_o, 32'h224);
        chk(ctl_o == 32'h0000_0200, "R11 ctl kept", ctl_o, 32'h0000_0200);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule